// File: doc/BRIEF.md
# Channel-Status Page Capture

This unit sits behind a digital-audio receiver's frame decoder and gathers the channel-status bit of every received frame into a page of six 32-bit words. One page holds 192 bits, which is one full block. Each frame arrives as a one-cycle strobe. The strobe carries the channel-status bit and a marker that says whether the frame opened with a block-start preamble. A separate strobe reports a preamble that was malformed or missing.

Bits fill each word from the least-significant end. Word 0 fills first, then word 1 and so on up to word 5, and after that filling wraps to word 0. A block-start frame always writes into word 0 bit 0, so the page stays aligned to the block boundary even after lost or extra frames.

Three sticky flags report page complete, block-start seen and bad preamble. A pulse on a flag's clear input clears it. A flag that is set and cleared in the same cycle stays set. A single interrupt line is the OR of those flags whose enable input is high. Any word can be read at any time through a word-select input.

Top module: `cs_rx_capture`

## Requirements
- R1: After reset every page word reads 0, all three flags are 0 and `irq` is 0.
- R2: Starting from bit position 0, the k-th captured bit (k from 0 to 191) is stored in word k/32 at bit k%32. Word 0 is selected by `rd_sel` value 0.
- R3: After position 191 is written, the next captured bit goes to word 0 bit 0 and overwrites the value stored there.
- R4: `flag_page_done` becomes 1 one cycle after the bit at position 191 is captured. It stays 0 while positions 0 to 190 are being written.
- R5: A captured frame with `frame_bstart` high writes its bit to word 0 bit 0 whatever the current position, the following frame writes to bit 1, and `flag_bstart_seen` becomes 1 the next cycle.
- R6: `preamble_err` high while `rx_enable` is high sets `flag_bad_preamble` the next cycle.
- R7: Each flag stays at 1 until its clear input is pulsed, and then it reads 0 the next cycle.
- R8: When a flag's set condition and its clear pulse fall in the same cycle, the flag reads 1 afterwards.
- R9: `irq` is 1 exactly when at least one flag is 1 and its enable input is 1. With every enable low, `irq` stays 0.
- R10: While `rx_enable` is low, frames and preamble errors change no page word and no flag.
- R11: A rising edge of `rx_enable` returns the write position to word 0 bit 0.
- R12: A `rd_sel` value of 6 or 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Capture enable; a rising edge restarts the page at position 0 |
| frame_valid | input | 1 | One-cycle strobe per received frame |
| frame_cs | input | 1 | Channel-status bit of the frame |
| frame_bstart | input | 1 | Frame began with a block-start preamble |
| preamble_err | input | 1 | Bad or missing preamble strobe |
| clr_page_done | input | 1 | Clear pulse for the page-complete flag |
| clr_bstart_seen | input | 1 | Clear pulse for the block-start flag |
| clr_bad_preamble | input | 1 | Clear pulse for the bad-preamble flag |
| ie_page_done | input | 1 | Interrupt enable for page complete |
| ie_bstart_seen | input | 1 | Interrupt enable for block-start seen |
| ie_bad_preamble | input | 1 | Interrupt enable for bad preamble |
| rd_sel | input | 3 | Page word select |
| rd_word | output | 32 | Selected page word |
| flag_page_done | output | 1 | Sticky page-complete flag |
| flag_bstart_seen | output | 1 | Sticky block-start-seen flag |
| flag_bad_preamble | output | 1 | Sticky bad-preamble flag |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench fills a whole page from position 0 and checks the complete flag after 191 frames and again after 192. A design with an off-by-one terminal count would raise the flag one frame early or one frame late. It then keeps writing past the end to confirm the wrap into word 0, which a design without the wrap would spill past or freeze. A block-start frame is sent from the middle of a page, and the bench checks the low bits of word 0 to catch a design that only marks the frame and does not realign. It also drives a set and a clear into the same flag in the same cycle, sends frames with capture disabled, and restarts capture to show that the position returns to 0.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Flag slots inside the sticky status vector.
  localparam int FLG_DONE  = 0;
  localparam int FLG_BSEEN = 1;
  localparam int FLG_PERR  = 2;
  localparam int NUM_FLAGS = 3;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/cs_bit_pointer.sv
module cs_bit_pointer #(
  parameter int PAGE_BITS = 192,
  parameter int PTR_W     = $clog2(PAGE_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             frame_valid,
  input  logic             blk_start,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             page_done
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PAGE_BITS - 1);

  logic             rx_en_q;
  logic [PTR_W-1:0] ptr_q, ptr_n, base;
  logic             rx_rise, capture;

  assign rx_rise = rx_en & ~rx_en_q;
  assign capture = rx_en & frame_valid;

  // Position used by this cycle's frame: block start or fresh enable forces 0.
  always_comb begin
    if (rx_rise || blk_start) base = '0;
    else                      base = ptr_q;
  end

  always_comb begin
    ptr_n = ptr_q;
    if (capture) begin
      if (base == LAST) ptr_n = '0;
      else              ptr_n = base + PTR_W'(1);
    end else if (rx_rise) begin
      ptr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      rx_en_q <= rx_en;
      ptr_q   <= ptr_n;
    end
  end

  assign wr_en     = capture;
  assign wr_idx    = base;
  assign page_done = capture && (base == LAST);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R3
  AST_BSTART_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && frame_valid && blk_start) |=> (ptr_q == PTR_W'(1))); // R5
  AST_RISE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_en_q && !frame_valid) |=> (ptr_q == '0)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/cs_page_store.sv
module cs_page_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  parameter int PTR_W     = $clog2(WORD_W * NUM_WORDS),
  parameter int SEL_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic              wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [NUM_WORDS-1:0][WORD_W-1:0] page_q;
  logic [SEL_W-1:0]                 wr_word;
  logic [BIT_W-1:0]                 wr_bit;

  assign wr_word = SEL_W'(wr_idx / PTR_W'(WORD_W));
  assign wr_bit  = BIT_W'(wr_idx % PTR_W'(WORD_W));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_n;
    logic              word_we;

    assign word_we = wr_en && (wr_word == SEL_W'(w));

    always_comb begin
      word_n = page_q[w];
      if (word_we) word_n[wr_bit] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q[w] <= '0;
      else if (word_we) page_q[w] <= word_n;
    end
  end

  always_comb begin
    if (rd_sel < SEL_W'(NUM_WORDS)) rd_word = page_q[rd_sel];
    else                            rd_word = '0;
  end

  AST_ONE_BIT_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(page_q ^ $past(page_q)) <= 1)); // R2
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(page_q)); // R10
endmodule

// File: rtl/cs_status_flags.sv
module cs_status_flags
  import cs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  input  flag_vec_t en_i,
  output flag_vec_t flag_o,
  output logic      irq_o
);
  flag_vec_t flag_q, flag_n;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    // Hardware set is applied after the clear, so it wins a collision.
    always_comb begin
      flag_n[i] = flag_q[i];
      if (clr_i[i]) flag_n[i] = 1'b0;
      if (set_i[i]) flag_n[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_n[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]); // R7
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/cs_rx_capture.sv
module cs_rx_capture
  import cs_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              frame_valid,
  input  logic              frame_cs,
  input  logic              frame_bstart,
  input  logic              preamble_err,
  input  logic              clr_page_done,
  input  logic              clr_bstart_seen,
  input  logic              clr_bad_preamble,
  input  logic              ie_page_done,
  input  logic              ie_bstart_seen,
  input  logic              ie_bad_preamble,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic              flag_page_done,
  output logic              flag_bstart_seen,
  output logic              flag_bad_preamble,
  output logic              irq
);
  localparam int PAGE_BITS = WORD_W * NUM_WORDS;
  localparam int PTR_W     = $clog2(PAGE_BITS);
  localparam int SEL_W     = 3;

  logic             wr_en, page_done;
  logic [PTR_W-1:0] wr_idx;
  flag_vec_t        set_v, clr_v, en_v, flag_v;

  cs_bit_pointer #(.PAGE_BITS(PAGE_BITS), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_enable), .frame_valid(frame_valid),
    .blk_start(frame_bstart), .wr_en(wr_en), .wr_idx(wr_idx),
    .page_done(page_done)
  );

  cs_page_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W),
                  .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(frame_cs), .rd_sel(rd_sel), .rd_word(rd_word)
  );

  always_comb begin
    set_v[FLG_DONE]  = page_done;
    set_v[FLG_BSEEN] = rx_enable & frame_valid & frame_bstart;
    set_v[FLG_PERR]  = rx_enable & preamble_err;
    clr_v = {clr_bad_preamble, clr_bstart_seen, clr_page_done};
    en_v  = {ie_bad_preamble, ie_bstart_seen, ie_page_done};
  end

  cs_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .en_i(en_v),
    .flag_o(flag_v), .irq_o(irq)
  );

  assign flag_page_done    = flag_v[FLG_DONE];
  assign flag_bstart_seen  = flag_v[FLG_BSEEN];
  assign flag_bad_preamble = flag_v[FLG_PERR];

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_page_done && !ie_bstart_seen && !ie_bad_preamble) |-> !irq); // R9
  AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !flag_bad_preamble) |=> !flag_bad_preamble); // R10
  AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_page_done && !page_done) |=> !flag_page_done); // R4
endmodule

// File: tb/cs_rx_capture_test.sv
`timescale 1ns/1ps
module cs_rx_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_enable, frame_valid, frame_cs, frame_bstart, preamble_err;
  logic        clr_page_done, clr_bstart_seen, clr_bad_preamble;
  logic        ie_page_done, ie_bstart_seen, ie_bad_preamble;
  logic [2:0]  rd_sel;
  logic [31:0] rd_word;
  logic        flag_page_done, flag_bstart_seen, flag_bad_preamble, irq;

  always #4 clk = ~clk; // 125 MHz

  cs_rx_capture uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .frame_valid(frame_valid),
    .frame_cs(frame_cs), .frame_bstart(frame_bstart), .preamble_err(preamble_err),
    .clr_page_done(clr_page_done), .clr_bstart_seen(clr_bstart_seen),
    .clr_bad_preamble(clr_bad_preamble), .ie_page_done(ie_page_done),
    .ie_bstart_seen(ie_bstart_seen), .ie_bad_preamble(ie_bad_preamble),
    .rd_sel(rd_sel), .rd_word(rd_word), .flag_page_done(flag_page_done),
    .flag_bstart_seen(flag_bstart_seen), .flag_bad_preamble(flag_bad_preamble),
    .irq(irq)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Bench model
  logic [191:0] m_page;
  int           m_ptr;
  logic [2:0]   m_flags; // {perr, bseen, done}
  logic [15:0]  lfsr = 16'hACE1;

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit cs, bit b, bit pe, bit [2:0] clr);
    @(negedge clk);
    frame_valid = v; frame_cs = cs; frame_bstart = b; preamble_err = pe;
    {clr_bad_preamble, clr_bstart_seen, clr_page_done} = clr;
    m_flags = m_flags & ~clr;
    if (rx_enable && v) begin
      if (b) begin m_ptr = 0; m_flags[1] = 1'b1; end
      m_page[m_ptr] = cs;
      if (m_ptr == 191) begin m_flags[0] = 1'b1; m_ptr = 0; end
      else m_ptr++;
    end
    if (rx_enable && pe) m_flags[2] = 1'b1;
    @(negedge clk);
    frame_valid = 0; frame_cs = 0; frame_bstart = 0; preamble_err = 0;
    {clr_bad_preamble, clr_bstart_seen, clr_page_done} = 3'b000;
  endtask

  task automatic check_page(string req);
    for (int w = 0; w < 6; w++) begin
      rd_sel = 3'(w);
      #1;
      chk(req, rd_word, m_page[w*32 +: 32]);
    end
  endtask

  task automatic check_flags(string req);
    chk(req, {29'd0, flag_bad_preamble, flag_bstart_seen, flag_page_done},
        {29'd0, m_flags});
  endtask

  task automatic t_reset();
    rst_n = 0; rx_enable = 0; frame_valid = 0; frame_cs = 0; frame_bstart = 0;
    preamble_err = 0; clr_page_done = 0; clr_bstart_seen = 0; clr_bad_preamble = 0;
    ie_page_done = 0; ie_bstart_seen = 0; ie_bad_preamble = 0; rd_sel = 0;
    m_page = '0; m_ptr = 0; m_flags = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_page("R1");
    check_flags("R1");
    chk("R1", {31'd0, irq}, 32'd0);
    rx_enable = 1; m_ptr = 0;
    @(negedge clk);
  endtask

  task automatic t_fill_page();
    for (int k = 0; k < 191; k++) drive(1, next_bit(), 0, 0, 3'b000);
    chk("R4 not before last bit", {31'd0, flag_page_done}, 32'd0);
    drive(1, next_bit(), 0, 0, 3'b000);
    chk("R4 set after bit 191", {31'd0, flag_page_done}, 32'd1);
    check_page("R2");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 5; k++) drive(1, ~m_page[k], 0, 0, 3'b000);
    rd_sel = 0; #1;
    chk("R3 wrap to word 0", rd_word, m_page[31:0]);
    drive(0, 0, 0, 0, 3'b001);
    check_flags("R7 clear done");
  endtask

  task automatic t_set_wins();
    drive(0, 0, 0, 1, 3'b000);
    check_flags("R6 bad preamble");
    drive(0, 0, 0, 1, 3'b100);
    check_flags("R8 set wins");
    chk("R8", {31'd0, flag_bad_preamble}, 32'd1);
    drive(0, 0, 0, 0, 3'b000);
    chk("R7 sticky", {31'd0, flag_bad_preamble}, 32'd1);
    drive(0, 0, 0, 0, 3'b100);
    chk("R7 cleared", {31'd0, flag_bad_preamble}, 32'd0);
  endtask

  task automatic t_bstart();
    for (int k = 0; k < 10; k++) drive(1, next_bit(), 0, 0, 3'b000);
    drive(1, ~m_page[0], 1, 0, 3'b000);
    drive(1, ~m_page[1], 0, 0, 3'b000);
    drive(1, ~m_page[2], 0, 0, 3'b000);
    rd_sel = 0; #1;
    chk("R5 resync word 0", rd_word, m_page[31:0]);
    check_page("R5");
    chk("R5 bseen", {31'd0, flag_bstart_seen}, 32'd1);
  endtask

  task automatic t_irq();
    drive(0, 0, 0, 1, 3'b000); // perr set too
    ie_page_done = 0; ie_bstart_seen = 0; ie_bad_preamble = 0; #1;
    chk("R9 all masked", {31'd0, irq}, 32'd0);
    ie_page_done = 1; #1;
    chk("R9 done masked-in while clear", {31'd0, irq}, {31'd0, m_flags[0]});
    ie_page_done = 0; ie_bstart_seen = 1; #1;
    chk("R9 bseen enabled", {31'd0, irq}, 32'd1);
    ie_bstart_seen = 0; ie_bad_preamble = 1; #1;
    chk("R9 perr enabled", {31'd0, irq}, 32'd1);
    drive(0, 0, 0, 0, 3'b111);
    chk("R9 no flags", {31'd0, irq}, 32'd0);
    ie_bad_preamble = 0;
  endtask

  task automatic t_disabled();
    @(negedge clk); rx_enable = 0;
    for (int k = 0; k < 8; k++) drive(1, ~m_page[k], k[0], 1, 3'b000);
    check_page("R10 words unchanged");
    check_flags("R10 flags unchanged");
  endtask

  task automatic t_rise();
    @(negedge clk); rx_enable = 1; m_ptr = 0;
    @(negedge clk);
    drive(1, ~m_page[0], 0, 0, 3'b000);
    drive(1, ~m_page[1], 0, 0, 3'b000);
    rd_sel = 0; #1;
    chk("R11 restart at bit 0", rd_word, m_page[31:0]);
  endtask

  task automatic t_bad_sel();
    rd_sel = 3'd6; #1;
    chk("R12 sel 6", rd_word, 32'd0);
    rd_sel = 3'd7; #1;
    chk("R12 sel 7", rd_word, 32'd0);
  endtask

  initial begin
    t_reset();
    t_fill_page();
    t_wrap();
    t_set_wins();
    t_bstart();
    t_irq();
    t_disabled();
    t_rise();
    t_bad_sel();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule